// File: doc/BRIEF.md
# Framed Serial Byte Stream Receiver

This block sits behind a UART receiver and turns its byte stream into framed messages. It watches for a two-byte start marker (0x02 then 0x55), reads a 16-bit payload count sent high byte first, and then writes the bytes that follow into an external message buffer through a simple write port. One input byte is handled per valid strobe, and a byte is written in the same cycle that it arrives. A frame holds the payload count plus a fixed number of trailer bytes.

The parser rejects a count that the buffer cannot hold. It also accepts one known corrupted start marker (0xA0 then 0x15) and treats it as a start whose high count byte is zero. If an external tick strobe arrives twice with no byte in between, the frame in progress is abandoned. When the last byte is stored, the parser pulses `frame_done` with the count and the receiver address byte. If that address is 3 or more, the parser locks out further input until `rx_rearm` is pulsed, so that the buffer contents stay intact for the consumer.

Top module: `frame_rx_parser`

## Requirements
- R1: Start sequence 0x02 then 0x55 is followed by two count bytes, high byte first, and then the stored bytes. A frame holds count + TRAILER stored bytes (TRAILER defaults to 4).
- R2: Recovery start: 0xA0 followed by 0x15 forces the high count byte to zero, and the next byte is taken as the low count byte. 0xA0 followed by any other byte returns to idle.
- R3: In idle, a byte other than 0x02 or 0xA0 is ignored. After 0x02, any byte other than 0x55 returns to idle. Nothing is written in either case.
- R4: A count above BUF_BYTES-7 (57 by default) drops the frame, and the bytes after it are not written. A count of exactly BUF_BYTES-7 is accepted.
- R5: The n-th stored byte (n counted from 0) raises `wr_en` with `wr_addr`=n and `wr_data` equal to the byte, in the same cycle as its `rx_valid`.
- R6: The cycle after the last stored byte, `frame_done` is high for exactly one cycle. At that point `frame_len` holds the count and `frame_rcv` holds stored byte index 1.
- R7: If the completed frame has `frame_rcv` >= 3, `rx_locked` rises with `frame_done`. While locked, input bytes cause no write and no frame. A `rx_rearm` pulse clears the lock.
- R8: A frame with `frame_rcv` < 3 leaves `rx_locked` low, and the next frame is accepted directly.
- R9: Each accepted byte reloads a 2-tick timeout. A second `tick` with no byte in between aborts the frame, and the next frame writes from address 0. A single tick does not abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| tick | input | 1 | Timeout time-base strobe |
| rx_rearm | input | 1 | Clears the reception lock |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | PW | Buffer write address |
| wr_data | output | 8 | Buffer write data |
| frame_done | output | 1 | One-cycle frame completion pulse |
| frame_len | output | 16 | Payload count of the last frame |
| frame_rcv | output | 8 | Receiver address of the last frame |
| rx_locked | output | 1 | Reception is disabled |

## Verification
The bench builds the block with its default parameters: a 64-byte buffer, a 4-byte trailer and a 2-tick timeout. With these values both sides of the length limit (57 accepted, 58 dropped) and the largest buffer address in use (60) can be reached within short frames. Random frames with random counts, payloads and receiver addresses on both sides of the lock threshold are mixed with directed cases for the recovery start, broken start sequences, oversize counts, a one-tick pause and a two-tick abort.

// File: rtl/frp_pkg.sv
package frp_pkg;
   typedef enum logic [2:0] {
      PS_IDLE  = 3'd0,
      PS_SYNC  = 3'd1,
      PS_CNTHI = 3'd2,
      PS_CNTLO = 3'd3,
      PS_STORE = 3'd4,
      PS_RECOV = 3'd5
   } parse_st_t;

   localparam logic [7:0] MARK_A    = 8'h02;
   localparam logic [7:0] MARK_B    = 8'h55;
   localparam logic [7:0] BAD_MARKA = 8'hA0;
   localparam logic [7:0] BAD_MARKB = 8'h15;
endpackage

// File: rtl/frp_timer.sv
module frp_timer #(
   parameter int TMO_TICKS = 2,
   localparam int TW = $clog2(TMO_TICKS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic clear,
   input  logic tick,
   output logic expire
);
   logic [TW-1:0] cnt_q;

   assign expire = tick && !load && !clear && (cnt_q == TW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clear)
         cnt_q <= '0;
      else if (load)
         cnt_q <= TW'(TMO_TICKS);
      else if (tick && cnt_q != '0)
         cnt_q <= cnt_q - TW'(1);
   end
endmodule

// File: rtl/frp_ctrl.sv
module frp_ctrl
   import frp_pkg::*;
#(
   parameter int BUF_BYTES  = 64,
   parameter int TRAILER    = 4,
   parameter int RCV_IDX    = 1,
   parameter bit RECOVER_EN = 1'b1,
   localparam int PW        = $clog2(BUF_BYTES),
   localparam int MAX_LEN   = BUF_BYTES - 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic [7:0]    data,
   input  logic          expire,
   output logic          wr_en,
   output logic [PW-1:0] wr_addr,
   output logic          done_now,
   output logic [7:0]    rcv_now,
   output logic          tmo_clear,
   output logic          frame_done,
   output logic [15:0]   frame_len,
   output logic [7:0]    frame_rcv
);
   parse_st_t     st_q, st_n;
   logic [15:0]   len_q, len_n;
   logic [PW-1:0] wptr_q, wptr_n;
   logic [7:0]    rcv_q, rcv_n;
   logic          bad_start;
   logic [16:0]   cnt_next, cnt_goal;

   generate
      if (RECOVER_EN) begin : g_recov
         assign bad_start = (data == BAD_MARKA);
      end else begin : g_norecov
         assign bad_start = 1'b0;
      end
   endgenerate

   assign cnt_next = {{(17-PW){1'b0}}, wptr_q} + 17'd1;
   assign cnt_goal = {1'b0, len_q} + 17'(TRAILER);
   assign wr_addr  = wptr_q;
   assign rcv_now  = (wptr_q == PW'(RCV_IDX)) ? data : rcv_q;

   always_comb begin
      st_n      = st_q;
      len_n     = len_q;
      wptr_n    = wptr_q;
      rcv_n     = rcv_q;
      wr_en     = 1'b0;
      done_now  = 1'b0;
      tmo_clear = 1'b0;
      if (expire) begin
         st_n   = PS_IDLE;
         wptr_n = '0;
      end
      if (accept) begin
         unique case (st_q)
            PS_IDLE: begin
               if (data == MARK_A)  st_n = PS_SYNC;
               else if (bad_start)  st_n = PS_RECOV;
            end
            PS_SYNC:  st_n = (data == MARK_B) ? PS_CNTHI : PS_IDLE;
            PS_CNTHI: begin
               len_n[15:8] = data;
               st_n        = PS_CNTLO;
            end
            PS_CNTLO: begin
               len_n[7:0] = data;
               wptr_n     = '0;
               st_n = ({len_q[15:8], data} > 16'(MAX_LEN)) ? PS_IDLE : PS_STORE;
            end
            PS_STORE: begin
               wr_en  = 1'b1;
               wptr_n = wptr_q + PW'(1);
               if (wptr_q == PW'(RCV_IDX)) rcv_n = data;
               if (cnt_next == cnt_goal) begin
                  done_now  = 1'b1;
                  tmo_clear = 1'b1;
                  wptr_n    = '0;
                  st_n      = PS_IDLE;
               end
            end
            PS_RECOV: begin
               if (data == BAD_MARKB) begin
                  len_n[15:8] = 8'h00;
                  st_n        = PS_CNTLO;
               end else begin
                  st_n = PS_IDLE;
               end
            end
            default: st_n = PS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= PS_IDLE;
         len_q      <= '0;
         wptr_q     <= '0;
         rcv_q      <= '0;
         frame_done <= 1'b0;
         frame_len  <= '0;
         frame_rcv  <= '0;
      end else begin
         st_q       <= st_n;
         len_q      <= len_n;
         wptr_q     <= wptr_n;
         rcv_q      <= rcv_n;
         frame_done <= done_now;
         if (done_now) begin
            frame_len <= len_q;
            frame_rcv <= rcv_now;
         end
      end
   end
endmodule

// File: rtl/frame_rx_parser.sv
module frame_rx_parser #(
   parameter int BUF_BYTES  = 64,
   parameter int TRAILER    = 4,
   parameter int RCV_IDX    = 1,
   parameter int TMO_TICKS  = 2,
   parameter int LOCK_MIN   = 3,
   parameter bit RECOVER_EN = 1'b1,
   localparam int PW        = $clog2(BUF_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic [7:0]    rx_data,
   input  logic          tick,
   input  logic          rx_rearm,
   output logic          wr_en,
   output logic [PW-1:0] wr_addr,
   output logic [7:0]    wr_data,
   output logic          frame_done,
   output logic [15:0]   frame_len,
   output logic [7:0]    frame_rcv,
   output logic          rx_locked
);
   generate
      if (BUF_BYTES < 8) begin : g_bad_buf
         $error("BUF_BYTES must be at least 8");
      end
      if (TRAILER <= RCV_IDX || TRAILER > 7) begin : g_bad_trl
         $error("TRAILER must exceed RCV_IDX and be at most 7");
      end
      if (TMO_TICKS < 1) begin : g_bad_tmo
         $error("TMO_TICKS must be at least 1");
      end
   endgenerate

   logic       accept, expire, done_now, tmo_clear, lock_q;
   logic [7:0] rcv_now;

   assign accept    = rx_valid && !lock_q;
   assign wr_data   = rx_data;
   assign rx_locked = lock_q;

   frp_timer #(.TMO_TICKS(TMO_TICKS)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(accept), .clear(tmo_clear),
      .tick(tick), .expire(expire)
   );

   frp_ctrl #(
      .BUF_BYTES(BUF_BYTES), .TRAILER(TRAILER), .RCV_IDX(RCV_IDX),
      .RECOVER_EN(RECOVER_EN)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .accept(accept), .data(rx_data),
      .expire(expire), .wr_en(wr_en), .wr_addr(wr_addr),
      .done_now(done_now), .rcv_now(rcv_now), .tmo_clear(tmo_clear),
      .frame_done(frame_done), .frame_len(frame_len), .frame_rcv(frame_rcv)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lock_q <= 1'b0;
      else if (rx_rearm)
         lock_q <= 1'b0;
      else if (done_now && rcv_now >= 8'(LOCK_MIN))
         lock_q <= 1'b1;
   end
endmodule

// File: rtl/frp_checker.sv
module frp_checker #(
   parameter int BUF_BYTES = 64,
   parameter int LOCK_MIN  = 3,
   parameter int PW        = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_valid,
   input logic          rx_rearm,
   input logic          wr_en,
   input logic [PW-1:0] wr_addr,
   input logic          frame_done,
   input logic [15:0]   frame_len,
   input logic [7:0]    frame_rcv,
   input logic          rx_locked
);
   // R5
   write_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (rx_valid && !rx_locked));
   // R4
   write_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_addr) <= BUF_BYTES - 4));
   // R4
   done_len_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (frame_len <= 16'(BUF_BYTES - 7)));
   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);
   // R7
   lock_on_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && frame_rcv >= 8'(LOCK_MIN)) |-> rx_locked);
   // R7
   lock_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_locked) |-> frame_done);
   // R7
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_locked && !rx_rearm) |=> rx_locked);
   // R8
   no_lock_low_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && frame_rcv < 8'(LOCK_MIN)) |-> !$rose(rx_locked));
endmodule

bind frame_rx_parser frp_checker #(
   .BUF_BYTES(BUF_BYTES), .LOCK_MIN(LOCK_MIN), .PW(PW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_rearm(rx_rearm),
   .wr_en(wr_en), .wr_addr(wr_addr), .frame_done(frame_done),
   .frame_len(frame_len), .frame_rcv(frame_rcv), .rx_locked(rx_locked)
);

// File: tb/sim_frame_rx_parser.sv
`timescale 1ns/1ps
module sim_frame_rx_parser;
   localparam int BUF = 64;
   localparam int TRL = 4;
   localparam int MAXL = BUF - 7;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       rx_valid = 1'b0, tick = 1'b0, rx_rearm = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic       wr_en, frame_done, rx_locked;
   logic [5:0] wr_addr;
   logic [7:0] wr_data, frame_rcv;
   logic [15:0] frame_len;

   int checks = 0, errors = 0, cycles = 0;
   logic [7:0] pay [0:255];

   frame_rx_parser u0 (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .tick(tick), .rx_rearm(rx_rearm), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .frame_done(frame_done), .frame_len(frame_len),
      .frame_rcv(frame_rcv), .rx_locked(rx_locked)
   );

   always #2.5 clk = ~clk;

   function automatic bit exp_lock(input logic [7:0] rcv);
      return rcv >= 8'd3;
   endfunction

   function automatic int exp_stored(input int len);
      return len + TRL;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // drive a byte right after a falling edge, observe the write port mid-cycle
   task automatic send_byte(input logic [7:0] b, output logic we,
                            output logic [5:0] a, output logic [7:0] d);
      rx_valid = 1'b1;
      rx_data  = b;
      #1;
      we = wr_en; a = wr_addr; d = wr_data;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic do_tick();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
   endtask

   // sends bytes with no expected write; returns count of writes seen
   task automatic send_junk(input logic [7:0] b, input int n, output int wrs);
      logic we; logic [5:0] a; logic [7:0] d;
      wrs = 0;
      for (int i = 0; i < n; i++) begin
         send_byte(b, we, a, d);
         if (we) wrs++;
      end
   endtask

   // full frame: payload pay[] already loaded, count = len
   task automatic send_frame(input int len, input bit recov, input string req);
      logic we; logic [5:0] a; logic [7:0] d;
      int bad = 0;
      int n = exp_stored(len);
      if (recov) begin
         send_byte(8'hA0, we, a, d); if (we) bad++;
         send_byte(8'h15, we, a, d); if (we) bad++;
      end else begin
         send_byte(8'h02, we, a, d); if (we) bad++;
         send_byte(8'h55, we, a, d); if (we) bad++;
         send_byte(8'(len >> 8), we, a, d); if (we) bad++;
      end
      send_byte(8'(len), we, a, d); if (we) bad++;
      for (int i = 0; i < n; i++) begin
         if (i > 0) chk(frame_done == 1'b0, "R6 early done", int'(frame_done), 0);
         send_byte(pay[i], we, a, d);
         if (!we || int'(a) != i || d != pay[i]) bad++;
      end
      chk(bad == 0, {req, " R5 write sequence"}, bad, 0);
      chk(frame_done == 1'b1, {req, " R6 done"}, int'(frame_done), 1);
      chk(int'(frame_len) == len, {req, " R6 len"}, int'(frame_len), len);
      chk(frame_rcv == pay[1], {req, " R6 rcv"}, int'(frame_rcv), int'(pay[1]));
      chk(rx_locked == exp_lock(pay[1]), {req, " R7/R8 lock"}, int'(rx_locked),
          int'(exp_lock(pay[1])));
      @(negedge clk);
      chk(frame_done == 1'b0, {req, " R6 single pulse"}, int'(frame_done), 0);
   endtask

   task automatic rearm();
      rx_rearm = 1'b1;
      @(negedge clk);
      rx_rearm = 1'b0;
   endtask

   task automatic fill(input logic [7:0] rcv);
      for (int i = 0; i < 256; i++) pay[i] = 8'($urandom);
      pay[1] = rcv;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            finish_run();
         end
      end
   end

   initial begin
      logic we; logic [5:0] a; logic [7:0] d;
      int wrs;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // reset state
      chk(wr_en == 1'b0 && frame_done == 1'b0, "R6 reset outputs", int'(frame_done), 0);
      chk(rx_locked == 1'b0, "R7 reset lock", int'(rx_locked), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 basic frame, low address: R8 no lock
      fill(8'h01);
      send_frame(5, 1'b0, "R1 basic");
      fill(8'h02);
      send_frame(0, 1'b0, "R8 follow-on zero count");

      // R7 lock with address 3, locked input ignored
      fill(8'h03);
      send_frame(2, 1'b0, "R7 lock");
      send_byte(8'h02, we, a, d); wrs = we ? 1 : 0;
      send_byte(8'h55, we, a, d); if (we) wrs++;
      send_byte(8'h00, we, a, d); if (we) wrs++;
      send_byte(8'h00, we, a, d); if (we) wrs++;
      for (int i = 0; i < 4; i++) begin send_byte(8'h11, we, a, d); if (we) wrs++; end
      chk(wrs == 0 && frame_done == 1'b0, "R7 locked ignores bytes", wrs, 0);
      chk(rx_locked == 1'b1, "R7 lock held", int'(rx_locked), 1);
      rearm();
      chk(rx_locked == 1'b0, "R7 rearm clears", int'(rx_locked), 0);
      fill(8'h00);
      send_frame(3, 1'b0, "R7 after rearm");

      // R2 recovery start
      fill(8'h00);
      send_frame(7, 1'b1, "R2 recovery");
      send_byte(8'hA0, we, a, d);
      send_byte(8'h55, we, a, d);
      send_junk(8'h00, 8, wrs);
      chk(wrs == 0 && frame_done == 1'b0, "R2 bad recovery returns idle", wrs, 0);

      // R3 junk in idle and broken second marker
      send_junk(8'h55, 6, wrs);
      chk(wrs == 0, "R3 idle junk", wrs, 0);
      send_byte(8'h02, we, a, d);
      send_byte(8'h54, we, a, d);
      send_junk(8'h00, 8, wrs);
      chk(wrs == 0 && frame_done == 1'b0, "R3 broken marker", wrs, 0);

      // R4 oversize dropped, exact limit accepted
      send_byte(8'h02, we, a, d);
      send_byte(8'h55, we, a, d);
      send_byte(8'h00, we, a, d);
      send_byte(8'(MAXL + 1), we, a, d);
      send_junk(8'h33, 8, wrs);
      chk(wrs == 0, "R4 oversize dropped", wrs, 0);
      send_byte(8'h02, we, a, d);
      send_byte(8'h55, we, a, d);
      send_byte(8'h01, we, a, d);
      send_byte(8'h00, we, a, d);
      send_junk(8'h33, 8, wrs);
      chk(wrs == 0, "R4 high count byte dropped", wrs, 0);
      fill(8'h00);
      send_frame(MAXL, 1'b0, "R4 limit");

      // R9 two ticks abort
      send_byte(8'h02, we, a, d);
      send_byte(8'h55, we, a, d);
      send_byte(8'h00, we, a, d);
      send_byte(8'h05, we, a, d);
      for (int i = 0; i < 3; i++) send_byte(8'h44, we, a, d);
      do_tick();
      do_tick();
      send_junk(8'h44, 3, wrs);
      chk(wrs == 0, "R9 abort returns idle", wrs, 0);
      fill(8'h00);
      send_frame(2, 1'b0, "R9 after abort");

      // R9 one tick does not abort
      for (int i = 0; i < 256; i++) pay[i] = 8'(i + 8'h20);
      pay[1] = 8'h00;
      send_byte(8'h02, we, a, d);
      send_byte(8'h55, we, a, d);
      send_byte(8'h00, we, a, d);
      send_byte(8'h03, we, a, d);
      wrs = 0;
      for (int i = 0; i < 7; i++) begin
         if (i == 2) do_tick();
         send_byte(pay[i], we, a, d);
         if (!we || int'(a) != i || d != pay[i]) wrs++;
      end
      chk(wrs == 0, "R9 one tick keeps frame", wrs, 0);
      chk(frame_done == 1'b1 && frame_len == 16'd3, "R9 one tick completes",
          int'(frame_len), 3);
      @(negedge clk);

      // random frames
      for (int k = 0; k < 60; k++) begin
         int len = int'($urandom_range(MAXL, 0));
         bit rv = 1'($urandom_range(1, 0));
         fill(8'($urandom_range(6, 0)));
         send_frame(len, rv, "R1 random");
         if (rx_locked) rearm();
         if ($urandom_range(3, 0) == 0) begin
            send_junk(8'h77, 2, wrs);
            chk(wrs == 0, "R3 random junk", wrs, 0);
         end
      end

      finish_run();
   end
endmodule